// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller gathers up to 32 interrupt request lines and reports to the processor the single most urgent one that may run now. It reports the line number, the line's urgency and a per-line handler address held in a register, so the processor can jump straight to the handler without a software lookup. Each line has its own enable, a three-bit urgency value and a choice between level and pulse sensing. All of these are set through a small word-addressed register bus.

Lines that the processor has taken are kept on an internal nesting stack. A new request is offered only when its urgency number is strictly lower than that of the handler now running, so a more urgent line preempts a less urgent one. An end-of-handler strobe pops the stack and restores the threshold of the handler that was interrupted. If another eligible request is waiting at that point, it is offered in the very next cycle and marked as chained, so the processor can enter it without restoring its context first.

The request side follows valid/ready rules. `req_valid` stays high while an eligible request exists. The offered line, vector and urgency may change before acceptance if a more urgent request arrives, or if software changes the configuration. A request is taken on a cycle where both `req_valid` and `req_ready` are high. In the cycle of an end-of-handler strobe `req_valid` is held low, so that taking a request and leaving a handler never happen in the same cycle.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset no request is offered, and the pending word (address 64), the active word (address 65) and every configuration word read as zero.
- R2: Address n (0..31) holds the 32-bit vector of line n. Address 32+n holds that line's control word: bit 0 enable, bit 1 pulse mode (0 = level), bits 4:2 urgency. Both read back as written.
- R3: A line whose enable bit is 0 is never offered, even while its pending bit is set.
- R4: Among eligible lines, the one with the lowest urgency number is offered, and ties go to the lowest line index. `req_vector` equals that line's vector register and `req_line` equals its index.
- R5: In level mode the line's pending bit (bit n of address 64) follows the input in the same cycle and holds nothing after the input drops.
- R6: In pulse mode a rising input edge sets a sticky pending bit. The bit stays set until the processor accepts that line.
- R7: Accepting a request sets the line's bit in the active word (address 65). From then on, only lines with a strictly lower urgency number than the newest active handler are offered.
- R8: Nesting: a more urgent request preempts a running handler. `eoi` clears the newest active line and restores the previous threshold. `eoi` with no active handler does nothing.
- R9: If a request is eligible in the cycle after `eoi`, it is offered in that cycle with `req_chain` high. `req_chain` is low for a request offered at any other time.
- R10: A change of a line's urgency takes effect on arbitration in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Interrupt request inputs, one per line |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| req_valid | output | 1 | An eligible request is offered |
| req_ready | input | 1 | Processor accepts the offered request |
| req_vector | output | 32 | Handler address of the offered line |
| req_line | output | 5 | Index of the offered line |
| req_prio | output | 3 | Urgency of the offered line |
| req_chain | output | 1 | Offered request directly follows an end-of-handler |
| eoi | input | 1 | End-of-handler strobe, pops the newest active handler |

## Verification
The assertions check four things on every cycle. An offered request is always enabled and strictly more urgent than the running handler. The count of active bits always matches the nesting depth. A sticky pulse flag is only lost through acceptance. A chained mark only appears right after an end-of-handler. Only the bench's scenarios show the rest: the arbitration order between particular lines, the exact vector value delivered, the threshold restored by popping a nested handler, and the difference between level and pulse pending as seen at the register bus.

// File: rtl/pvic_pkg.sv
`timescale 1ns/1ps
package pvic_pkg;
  parameter int unsigned NLINES  = 32;
  parameter int unsigned URG_W   = 3;
  parameter int unsigned DATA_W  = 32;

  // control word layout: {urgency, pulse, enable}
  typedef struct packed {
    logic [URG_W-1:0] urg;
    logic             pulse;
    logic             en;
  } line_ctrl_t;

  localparam int unsigned CTRL_W = $bits(line_ctrl_t);
endpackage

// File: rtl/pvic_regs.sv
`timescale 1ns/1ps
module pvic_regs #(
  parameter int unsigned LINES  = pvic_pkg::NLINES,
  parameter int unsigned DATA_W = pvic_pkg::DATA_W,
  parameter int unsigned URG_W  = pvic_pkg::URG_W,
  parameter int unsigned ADDR_W = $clog2(2*LINES+2)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic [LINES-1:0]        pend_mon,
  input  logic [LINES-1:0]        act_mon,
  output logic [DATA_W-1:0]       vec_tab [LINES],
  output logic [LINES-1:0]        en_vec,
  output logic [LINES-1:0]        pulse_vec,
  output logic [LINES-1:0][URG_W-1:0] urg_vec
);
  import pvic_pkg::*;

  localparam int unsigned CTRL_BASE = LINES;
  localparam int unsigned PEND_ADDR = 2*LINES;
  localparam int unsigned ACT_ADDR  = 2*LINES + 1;

  line_ctrl_t ctrl [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_tab[g] <= '0;
        ctrl[g]    <= '0;
      end else if (we) begin
        if (addr == ADDR_W'(g))
          vec_tab[g] <= wdata;
        if (addr == ADDR_W'(CTRL_BASE + g))
          ctrl[g] <= line_ctrl_t'(wdata[CTRL_W-1:0]);
      end
    end
    assign en_vec[g]    = ctrl[g].en;
    assign pulse_vec[g] = ctrl[g].pulse;
    assign urg_vec[g]   = ctrl[g].urg;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < LINES; i++) begin
      if (addr == ADDR_W'(i))
        rdata = vec_tab[i];
      if (addr == ADDR_W'(CTRL_BASE + i))
        rdata = DATA_W'(ctrl[i]);
    end
    if (addr == ADDR_W'(PEND_ADDR))
      rdata = DATA_W'(pend_mon);
    if (addr == ADDR_W'(ACT_ADDR))
      rdata = DATA_W'(act_mon);
  end

  // R2: a write to line 0's control word lands in its fields
  p_ctrl_write_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(CTRL_BASE)) |=>
      (DATA_W'(ctrl[0]) == DATA_W'($past(wdata[CTRL_W-1:0]))));
endmodule

// File: rtl/pvic_pend.sv
`timescale 1ns/1ps
module pvic_pend #(
  parameter int unsigned LINES = pvic_pkg::NLINES,
  localparam int unsigned ID_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq,
  input  logic [LINES-1:0] pulse_mode,
  input  logic             clr_en,
  input  logic [ID_W-1:0]  clr_id,
  output logic [LINES-1:0] pending
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic prev_q;
    logic sticky_q;
    logic rise;
    logic clr_me;

    assign rise   = irq[g] && !prev_q;
    assign clr_me = clr_en && (clr_id == ID_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q   <= 1'b0;
        sticky_q <= 1'b0;
      end else begin
        prev_q <= irq[g];
        if (pulse_mode[g] && rise)
          sticky_q <= 1'b1;
        else if (clr_me)
          sticky_q <= 1'b0;
      end
    end

    assign pending[g] = pulse_mode[g] ? sticky_q : irq[g];

    // R6: a sticky flag is lost only through acceptance of this line
    p_sticky_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q && !clr_me) |=> sticky_q);
  end
endmodule

// File: rtl/pvic_arb.sv
`timescale 1ns/1ps
module pvic_arb #(
  parameter int unsigned LINES = pvic_pkg::NLINES,
  parameter int unsigned URG_W = pvic_pkg::URG_W,
  localparam int unsigned ID_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]            elig,
  input  logic [LINES-1:0][URG_W-1:0] urg,
  input  logic [URG_W:0]              thresh,
  output logic                        found,
  output logic [ID_W-1:0]             win_id,
  output logic [URG_W-1:0]            win_urg
);
  // scan upward; strict compare keeps the lowest index on ties
  always_comb begin
    found   = 1'b0;
    win_id  = '0;
    win_urg = '1;
    for (int i = 0; i < LINES; i++) begin
      if (elig[i] && ({1'b0, urg[i]} < thresh) &&
          (!found || (urg[i] < win_urg))) begin
        found   = 1'b1;
        win_id  = ID_W'(i);
        win_urg = urg[i];
      end
    end
  end
endmodule

// File: rtl/pvic_stack.sv
`timescale 1ns/1ps
module pvic_stack #(
  parameter int unsigned URG_W = pvic_pkg::URG_W,
  parameter int unsigned ID_W  = 5,
  localparam int unsigned DEPTH = 2**URG_W,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [URG_W-1:0] push_urg,
  input  logic [ID_W-1:0]  push_id,
  input  logic             pop,
  output logic [URG_W:0]   thresh,
  output logic [ID_W-1:0]  top_id,
  output logic             nonempty,
  output logic [CNT_W-1:0] level
);
  logic [URG_W-1:0] urg_mem [DEPTH];
  logic [ID_W-1:0]  id_mem  [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx;

  assign top_idx  = IDX_W'(cnt_q - 1'b1);
  assign nonempty = (cnt_q != '0);
  assign level    = cnt_q;
  assign top_id   = id_mem[top_idx];
  assign thresh   = nonempty ? {1'b0, urg_mem[top_idx]} : {1'b1, {URG_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        urg_mem[i] <= '0;
        id_mem[i]  <= '0;
      end
    end else if (pop && nonempty) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (push) begin
      urg_mem[IDX_W'(cnt_q)] <= push_urg;
      id_mem[IDX_W'(cnt_q)]  <= push_id;
      cnt_q                  <= cnt_q + 1'b1;
    end
  end

  // R8: strict preemption bounds nesting to one entry per urgency level
  p_no_overflow_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));
  // R8: a pushed entry is strictly more urgent than the one below it
  p_push_urgent_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> ({1'b0, push_urg} < thresh));
endmodule

// File: rtl/prio_vec_intc.sv
`timescale 1ns/1ps
module prio_vec_intc #(
  parameter int unsigned LINES  = pvic_pkg::NLINES,
  parameter int unsigned URG_W  = pvic_pkg::URG_W,
  parameter int unsigned DATA_W = pvic_pkg::DATA_W,
  parameter int unsigned ADDR_W = $clog2(2*LINES+2),
  parameter int unsigned ID_W   = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_lines,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DATA_W-1:0] req_vector,
  output logic [ID_W-1:0]   req_line,
  output logic [URG_W-1:0]  req_prio,
  output logic              req_chain,
  input  logic              eoi
);
  localparam int unsigned CNT_W = $clog2(2**URG_W + 1);

  logic [DATA_W-1:0]            vec_tab [LINES];
  logic [LINES-1:0]             en_vec, pulse_vec, pending, active_q, elig;
  logic [LINES-1:0][URG_W-1:0]  urg_vec;
  logic [URG_W:0]               thresh;
  logic [ID_W-1:0]              top_id, win_id;
  logic [URG_W-1:0]             win_urg;
  logic [CNT_W-1:0]             level;
  logic                         found, nonempty, fire, pop, chain_q;

  pvic_regs #(.LINES(LINES), .DATA_W(DATA_W), .URG_W(URG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .pend_mon(pending), .act_mon(active_q), .vec_tab(vec_tab),
    .en_vec(en_vec), .pulse_vec(pulse_vec), .urg_vec(urg_vec)
  );

  pvic_pend #(.LINES(LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq(irq_lines), .pulse_mode(pulse_vec),
    .clr_en(fire), .clr_id(win_id), .pending(pending)
  );

  assign elig = pending & en_vec & ~active_q;

  pvic_arb #(.LINES(LINES), .URG_W(URG_W)) u_arb (
    .elig(elig), .urg(urg_vec), .thresh(thresh),
    .found(found), .win_id(win_id), .win_urg(win_urg)
  );

  pvic_stack #(.URG_W(URG_W), .ID_W(ID_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(fire), .push_urg(win_urg), .push_id(win_id),
    .pop(pop), .thresh(thresh), .top_id(top_id), .nonempty(nonempty), .level(level)
  );

  assign req_valid  = found && !eoi;
  assign fire       = req_valid && req_ready;
  assign pop        = eoi && nonempty;
  assign req_line   = win_id;
  assign req_prio   = win_urg;
  assign req_vector = vec_tab[win_id];
  assign req_chain  = req_valid && chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      chain_q  <= 1'b0;
    end else begin
      if (pop)
        active_q[top_id] <= 1'b0;
      else if (fire)
        active_q[win_id] <= 1'b1;
      chain_q <= eoi;
    end
  end

  // R3: only enabled lines are offered
  p_req_enabled_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> en_vec[req_line]);
  // R7: an offered request beats the running handler
  p_req_urgent_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, req_prio} < thresh));
  // R8: active bits track the nesting depth
  p_active_depth_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(active_q) == int'(level)));
  // R8: end-of-handler retires the newest active line
  p_eoi_retires_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !active_q[$past(top_id)]);
  // R9: a chained mark only follows an end-of-handler
  p_chain_origin_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    req_chain |-> $past(eoi));
endmodule

// File: tb/sim_prio_vec_intc.sv
`timescale 1ns/1ps
module sim_prio_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_vector;
  logic [4:0]  req_line;
  logic [2:0]  req_prio;
  logic        req_chain;
  logic        eoi = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_vec_intc u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
    .req_line(req_line), .req_prio(req_prio), .req_chain(req_chain), .eoi(eoi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 7'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    #1;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 7'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic set_line(input int n, input bit en, input bit pulse, input int urg);
    wr(32 + n, {27'd0, 3'(urg), pulse, en});
  endtask

  task automatic accept();
    @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    #1;
  endtask

  task automatic end_handler();
    @(negedge clk);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 no request", 32'(req_valid), 0);
    rd(64, d); check("R1 pending", d, 0);
    rd(65, d); check("R1 active", d, 0);
    rd(5, d);  check("R1 vector reg", d, 0);
    rd(40, d); check("R1 ctrl reg", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    for (int n = 0; n < 32; n++) wr(n, 32'h1000 + 32'(n) * 4);
    rd(9, d);  check("R2 vector 9", d, 32'h1024);
    rd(31, d); check("R2 vector 31", d, 32'h107C);
    set_line(17, 1'b1, 1'b1, 6);
    rd(49, d); check("R2 ctrl 17", d, 32'h1B);
    set_line(17, 1'b0, 1'b0, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    set_line(3, 1'b0, 1'b0, 1);
    irq_lines[3] = 1'b1;
    step();
    check("R3 disabled not offered", 32'(req_valid), 0);
    rd(64, d); check("R3 pending while disabled", d, 32'h8);
    set_line(3, 1'b1, 1'b0, 1);
    check("R3 offered once enabled", 32'(req_valid), 1);
    check("R4 line 3 id", 32'(req_line), 3);
    check("R4 line 3 vector", req_vector, 32'h100C);
    set_line(3, 1'b0, 1'b0, 1);
    irq_lines[3] = 1'b0;
    step();
  endtask

  task automatic t_priority();
    set_line(5, 1'b1, 1'b0, 2);
    set_line(9, 1'b1, 1'b0, 1);
    set_line(12, 1'b1, 1'b0, 1);
    @(negedge clk);
    irq_lines[5] = 1'b1; irq_lines[9] = 1'b1; irq_lines[12] = 1'b1;
    #1;
    check("R4 urgency then index", 32'(req_line), 9);
    check("R4 winner vector", req_vector, 32'h1024);
    check("R4 winner urgency", 32'(req_prio), 1);
    set_line(12, 1'b1, 1'b0, 0);
    check("R10 retune line 12", 32'(req_line), 12);
    set_line(9, 1'b1, 1'b0, 0);
    check("R10 tie back to index", 32'(req_line), 9);
    @(negedge clk);
    irq_lines = '0;
    #1;
    check("R5 level drop clears request", 32'(req_valid), 0);
    set_line(5, 1'b0, 1'b0, 0);
    set_line(9, 1'b0, 1'b0, 0);
    set_line(12, 1'b0, 1'b0, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_line(7, 1'b0, 1'b0, 3);
    @(negedge clk);
    irq_lines[7] = 1'b1;
    #1;
    rd(64, d); check("R5 level follows high", d, 32'h80);
    step(); step();
    @(negedge clk);
    irq_lines[7] = 1'b0;
    #1;
    rd(64, d); check("R5 level follows low", d, 0);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    set_line(20, 1'b1, 1'b1, 4);
    @(negedge clk);
    irq_lines[20] = 1'b1;
    @(negedge clk);
    irq_lines[20] = 1'b0;
    #1;
    step(); step();
    rd(64, d); check("R6 sticky after pulse", d, 32'h0010_0000);
    check("R6 pulse offered", 32'(req_line), 20);
    check("R6 pulse valid", 32'(req_valid), 1);
    accept();
    rd(64, d); check("R6 cleared on accept", d, 0);
    rd(65, d); check("R7 active after accept", d, 32'h0010_0000);
    check("R7 no re-offer", 32'(req_valid), 0);
    end_handler();
    rd(65, d); check("R8 active cleared by eoi", d, 0);
    end_handler();
    rd(65, d); check("R8 eoi on empty ignored", d, 0);
    check("R8 eoi on empty no request", 32'(req_valid), 0);
    set_line(20, 1'b0, 1'b0, 0);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    set_line(4, 1'b1, 1'b0, 5);
    set_line(6, 1'b1, 1'b0, 5);
    set_line(8, 1'b1, 1'b0, 2);
    @(negedge clk);
    irq_lines[4] = 1'b1;
    #1;
    check("R4 first handler line", 32'(req_line), 4);
    check("R9 no chain on fresh request", 32'(req_chain), 0);
    accept();
    @(negedge clk);
    irq_lines[6] = 1'b1;
    #1;
    check("R7 equal urgency blocked", 32'(req_valid), 0);
    @(negedge clk);
    irq_lines[8] = 1'b1;
    #1;
    check("R8 preempting line", 32'(req_line), 8);
    check("R8 preempt valid", 32'(req_valid), 1);
    accept();
    rd(65, d); check("R8 two active", d, 32'h110);
    @(negedge clk);
    irq_lines[8] = 1'b0;
    #1;
    end_handler();
    rd(65, d); check("R8 pop restores outer", d, 32'h10);
    check("R8 threshold restored", 32'(req_valid), 0);
    check("R9 no chain without request", 32'(req_chain), 0);
    @(negedge clk);
    irq_lines[4] = 1'b0;
    #1;
    end_handler();
    check("R9 chained request valid", 32'(req_valid), 1);
    check("R9 chained line", 32'(req_line), 6);
    check("R9 chain flag", 32'(req_chain), 1);
    accept();
    rd(65, d); check("R9 chained active", d, 32'h40);
    @(negedge clk);
    irq_lines[6] = 1'b0;
    #1;
    end_handler();
    rd(65, d); check("R8 all retired", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_regs();
    t_disabled();
    t_priority();
    t_level();
    t_pulse();
    t_nest();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule